// File: doc/BRIEF.md
# Integer Execute ALU with Immediate Operand Forms

This block is the combinational integer execute stage of a small load/store processor core. Each evaluation takes an operation selected by a 6-bit major code and a 6-bit function code. It also takes two 32-bit register values, a 16-bit immediate and a 5-bit shift-amount field. From these it returns a 32-bit result and a signed-overflow flag, both in the same cycle. The surrounding pipeline supplies the operands and the decoded instruction fields. It latches the result, and it raises a trap whenever the overflow flag is set.

The register-register group shares major code 0x00, and the function code picks the operation inside that group. Every immediate operation has its own major code. The operation set covers several groups:

- Trapping add and subtract, plus their non-flagging unsigned forms.
- Bitwise AND, OR and XOR.
- A load of the upper half of the result.
- Signed and unsigned less-than compares. These compare the operands directly and never go through a subtraction that could overflow.
- Logical and arithmetic shifts, by a fixed field or by a count held in a register.

Loading the upper half and then applying OR-immediate builds any 32-bit constant.

Top module: `alu_exec`

## Requirements
- R1: ADD (major 0x00, function 0x20), SUB (major 0x00, function 0x22) and ADDI (major 0x08) return A+B, A-B and A+sext(imm), each wrapping modulo 2^32.
- R2: ADDU (function 0x21), SUBU (function 0x23) and ADDIU (major 0x09) return the same values as the trapping forms, and the overflow flag always stays 0 for them.
- R3: LUI (major 0x0F) returns the immediate in bits 31:16 and zero in bits 15:0, whatever A and B are.
- R4: The overflow flag is 1 only for ADD, SUB and ADDI, and only when the exact signed result cannot fit in 32 bits.
- R5: AND, OR and XOR (functions 0x24, 0x25, 0x26) combine A with B. ANDI, ORI and XORI (majors 0x0C, 0x0D, 0x0E) combine A with the zero-extended immediate. B has no effect on the immediate forms.
- R6: SLT (function 0x2A) and SLTI (major 0x0A) return 1 when A is less than the second operand as signed values, and 0 otherwise. The immediate is sign-extended. The answer is correct even when A-B would overflow.
- R7: SLTU (function 0x2B) and SLTIU (major 0x0B) do the same compare on unsigned values. The immediate is sign-extended first.
- R8: SLL, SRL and SRA (functions 0x00, 0x02, 0x03) shift A by the 5-bit shift-amount field. SRA fills with the sign of A, and the other two fill with zero.
- R9: SLLV, SRLV and SRAV (functions 0x04, 0x06, 0x07) shift A by B[4:0]. The upper bits of B are ignored.
- R10: Any major or function code not listed above returns result 0 with the overflow flag at 0.
- R11: ORI applied to an LUI result puts the new immediate into bits 15:0 and keeps bits 31:16. For example, LUI 0x4083 followed by ORI 0xF3A4 gives 0x4083F3A4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_major | input | 6 | Major operation code |
| op_func | input | 6 | Function code, decoded only when the major code is 0x00 |
| shamt | input | 5 | Shift amount for the fixed-count shifts |
| a_val | input | 32 | First register operand |
| b_val | input | 32 | Second register operand, or the shift count for the variable shifts |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow from a trapping add or subtract |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath and a 16-bit immediate. At these widths the model can be written in 64-bit integer arithmetic, so signed overflow and the compares are computed exactly rather than through sign-bit rules. The random operands mix in extreme values such as 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and small numbers. This drives the overflow boundary, the sign-split cases of the compare, and shift counts of 0 and 31 far more often than uniform random values would.

// File: rtl/alu_exec_pkg.sv
`timescale 1ns/1ps
package alu_exec_pkg;
  // major codes
  localparam logic [5:0] MJ_REG   = 6'h00;
  localparam logic [5:0] MJ_ADDI  = 6'h08;
  localparam logic [5:0] MJ_ADDIU = 6'h09;
  localparam logic [5:0] MJ_SLTI  = 6'h0A;
  localparam logic [5:0] MJ_SLTIU = 6'h0B;
  localparam logic [5:0] MJ_ANDI  = 6'h0C;
  localparam logic [5:0] MJ_ORI   = 6'h0D;
  localparam logic [5:0] MJ_XORI  = 6'h0E;
  localparam logic [5:0] MJ_LUI   = 6'h0F;
  // function codes within MJ_REG
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    OPK_NONE, OPK_ADD, OPK_SUB, OPK_AND, OPK_OR, OPK_XOR,
    OPK_LUI, OPK_SLT, OPK_SLTU, OPK_SHL, OPK_SHR
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     use_imm;      // second operand comes from the immediate
    logic     imm_sext;     // sign-extend rather than zero-extend
    logic     traps;        // overflow is reported
    logic     arith;        // right shift fills with sign
    logic     cnt_from_reg; // shift count taken from b_val
  } dec_t;
endpackage

// File: rtl/alu_exec_decode.sv
`timescale 1ns/1ps
module alu_exec_decode
  import alu_exec_pkg::*;
(
  input  logic [5:0] op_major,
  input  logic [5:0] op_func,
  output dec_t       dec
);
  always_comb begin
    dec = '{kind: OPK_NONE, use_imm: 1'b0, imm_sext: 1'b0, traps: 1'b0,
            arith: 1'b0, cnt_from_reg: 1'b0};
    unique case (op_major)
      MJ_REG: begin
        unique case (op_func)
          FN_SLL:  dec.kind = OPK_SHL;
          FN_SRL:  dec.kind = OPK_SHR;
          FN_SRA:  begin dec.kind = OPK_SHR; dec.arith = 1'b1; end
          FN_SLLV: begin dec.kind = OPK_SHL; dec.cnt_from_reg = 1'b1; end
          FN_SRLV: begin dec.kind = OPK_SHR; dec.cnt_from_reg = 1'b1; end
          FN_SRAV: begin dec.kind = OPK_SHR; dec.cnt_from_reg = 1'b1; dec.arith = 1'b1; end
          FN_ADD:  begin dec.kind = OPK_ADD; dec.traps = 1'b1; end
          FN_ADDU: dec.kind = OPK_ADD;
          FN_SUB:  begin dec.kind = OPK_SUB; dec.traps = 1'b1; end
          FN_SUBU: dec.kind = OPK_SUB;
          FN_AND:  dec.kind = OPK_AND;
          FN_OR:   dec.kind = OPK_OR;
          FN_XOR:  dec.kind = OPK_XOR;
          FN_SLT:  dec.kind = OPK_SLT;
          FN_SLTU: dec.kind = OPK_SLTU;
          default: dec.kind = OPK_NONE;
        endcase
      end
      MJ_ADDI:  begin dec.kind = OPK_ADD;  dec.use_imm = 1'b1; dec.imm_sext = 1'b1; dec.traps = 1'b1; end
      MJ_ADDIU: begin dec.kind = OPK_ADD;  dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
      MJ_SLTI:  begin dec.kind = OPK_SLT;  dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
      MJ_SLTIU: begin dec.kind = OPK_SLTU; dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
      MJ_ANDI:  begin dec.kind = OPK_AND;  dec.use_imm = 1'b1; end
      MJ_ORI:   begin dec.kind = OPK_OR;   dec.use_imm = 1'b1; end
      MJ_XORI:  begin dec.kind = OPK_XOR;  dec.use_imm = 1'b1; end
      MJ_LUI:   begin dec.kind = OPK_LUI;  dec.use_imm = 1'b1; end
      default:  dec.kind = OPK_NONE;
    endcase
  end
endmodule

// File: rtl/alu_exec_addsub.sv
`timescale 1ns/1ps
module alu_exec_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_evt,
  output logic         lt_signed,
  output logic         lt_unsigned
);
  function automatic logic [W-1:0] add_w(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic cin);
    return x + y + {{(W-1){1'b0}}, cin};
  endfunction

  // sign rule: same-sign inputs (after inversion for subtract) giving an opposite-sign sum
  function automatic logic sign_ovf(input logic sa, input logic sb, input logic ss, input logic is_sub);
    logic sb_eff;
    sb_eff = is_sub ? ~sb : sb;
    return (sa == sb_eff) && (ss != sa);
  endfunction

  // compare without subtraction: sign bits settle mixed-sign cases
  function automatic logic less_signed(input logic [W-1:0] x, input logic [W-1:0] y);
    if (x[W-1] != y[W-1]) return x[W-1];
    return x[W-2:0] < y[W-2:0];
  endfunction

  always_comb begin
    sum         = add_w(a, sub ? ~b : b, sub);
    ovf_evt     = sign_ovf(a[W-1], b[W-1], sum[W-1], sub);
    lt_signed   = less_signed(a, b);
    lt_unsigned = a < b;
  end
endmodule

// File: rtl/alu_exec_shift.sv
`timescale 1ns/1ps
module alu_exec_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  logic [SHW-1:0] cnt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   res
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stg [0:SHW];
  logic         fill;

  assign fill = arith & ~left & val[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i] = val[W-1-i];
    assign rev_out[i] = stg[SHW][W-1-i];
  end

  // a left shift runs through the same right-shift stages on a mirrored word
  assign stg[0] = left ? rev_in : val;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int SH = 2 ** s;
    assign stg[s+1] = cnt[s] ? {{SH{fill}}, stg[s][W-1:SH]} : stg[s];
  end

  assign res = left ? rev_out : stg[SHW];
endmodule

// File: rtl/alu_exec.sv
`timescale 1ns/1ps
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [5:0]      op_major,
  input  logic [5:0]      op_func,
  input  logic [SHW-1:0]  shamt,
  input  logic [XLEN-1:0] a_val,
  input  logic [XLEN-1:0] b_val,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] result,
  output logic            ovf
);
  localparam int PADW = XLEN - IMMW;

  dec_t            dec;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] sum_raw;
  logic [XLEN-1:0] shift_res;
  logic [SHW-1:0]  sh_cnt;
  logic            add_ovf_evt;
  logic            lt_signed;
  logic            lt_unsigned;
  logic            is_addsub;

  alu_exec_decode u_dec (
    .op_major (op_major),
    .op_func  (op_func),
    .dec      (dec)
  );

  assign imm_ext = dec.imm_sext ? {{PADW{imm[IMMW-1]}}, imm} : {{PADW{1'b0}}, imm};
  assign opnd_b  = dec.use_imm ? imm_ext : b_val;
  assign sh_cnt  = dec.cnt_from_reg ? b_val[SHW-1:0] : shamt;

  alu_exec_addsub #(.W(XLEN)) u_addsub (
    .a           (a_val),
    .b           (opnd_b),
    .sub         (dec.kind == OPK_SUB),
    .sum         (sum_raw),
    .ovf_evt     (add_ovf_evt),
    .lt_signed   (lt_signed),
    .lt_unsigned (lt_unsigned)
  );

  alu_exec_shift #(.W(XLEN), .SHW(SHW)) u_shift (
    .val   (a_val),
    .cnt   (sh_cnt),
    .left  (dec.kind == OPK_SHL),
    .arith (dec.arith),
    .res   (shift_res)
  );

  assign is_addsub = (dec.kind == OPK_ADD) || (dec.kind == OPK_SUB);

  always_comb begin
    unique case (dec.kind)
      OPK_ADD, OPK_SUB: result = sum_raw;
      OPK_AND:          result = a_val & opnd_b;
      OPK_OR:           result = a_val | opnd_b;
      OPK_XOR:          result = a_val ^ opnd_b;
      OPK_LUI:          result = {imm, {PADW{1'b0}}};
      OPK_SLT:          result = {{(XLEN-1){1'b0}}, lt_signed};
      OPK_SLTU:         result = {{(XLEN-1){1'b0}}, lt_unsigned};
      OPK_SHL, OPK_SHR: result = shift_res;
      default:          result = '0;
    endcase
  end

  assign ovf = dec.traps & is_addsub & add_ovf_evt;
endmodule

// File: rtl/alu_exec_chk.sv
`timescale 1ns/1ps
module alu_exec_chk
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  parameter int SHW  = 5
) (
  input logic [5:0]      op_major,
  input logic [5:0]      op_func,
  input logic [SHW-1:0]  shamt,
  input logic [XLEN-1:0] a_val,
  input logic [XLEN-1:0] b_val,
  input logic [IMMW-1:0] imm,
  input logic [XLEN-1:0] result,
  input logic            ovf,
  input logic            add_ovf_evt
);
  logic is_reg, unsigned_form, trap_form, cmp_form;

  always_comb begin
    is_reg        = (op_major == MJ_REG);
    unsigned_form = (op_major == MJ_ADDIU) ||
                    (is_reg && (op_func == FN_ADDU || op_func == FN_SUBU));
    trap_form     = (op_major == MJ_ADDI) ||
                    (is_reg && (op_func == FN_ADD || op_func == FN_SUB));
    cmp_form      = (op_major == MJ_SLTI) || (op_major == MJ_SLTIU) ||
                    (is_reg && (op_func == FN_SLT || op_func == FN_SLTU));

    if (op_major == MJ_LUI)
      AST_LUI_LAYOUT: assert (result == {imm, {(XLEN-IMMW){1'b0}}}); // R3
    if (unsigned_form)
      AST_UNSIGNED_NO_OVF: assert (!ovf); // R2
    if (ovf)
      AST_OVF_TRAP_ONLY: assert (trap_form && add_ovf_evt); // R4
    if (cmp_form)
      AST_CMP_BINARY: assert (result[XLEN-1:1] == '0); // R6
    if (is_reg && op_func == FN_SLT && a_val[XLEN-1] != b_val[XLEN-1])
      AST_SLT_SIGN_SPLIT: assert (result[0] == a_val[XLEN-1]); // R6
    if (op_major == MJ_ANDI || op_major == MJ_ORI || op_major == MJ_XORI)
      AST_IMM_LOGIC_HIGH: assert (result[XLEN-1:IMMW] == a_val[XLEN-1:IMMW]
                                  || op_major == MJ_ANDI); // R5
    if (op_major == MJ_ANDI)
      AST_ANDI_HIGH_ZERO: assert (result[XLEN-1:IMMW] == '0); // R5
  end

  logic unused_ok;
  assign unused_ok = ^shamt;
endmodule

bind alu_exec alu_exec_chk #(.XLEN(XLEN), .IMMW(IMMW), .SHW(SHW)) u_chk (
  .op_major    (op_major),
  .op_func     (op_func),
  .shamt       (shamt),
  .a_val       (a_val),
  .b_val       (b_val),
  .imm         (imm),
  .result      (result),
  .ovf         (ovf),
  .add_ovf_evt (add_ovf_evt)
);

// File: tb/alu_exec_test.sv
`timescale 1ns/1ps
module alu_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_major = '0;
  logic [5:0]  op_func = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] a_val = '0;
  logic [31:0] b_val = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        ovf;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  alu_exec uut (
    .op_major (op_major),
    .op_func  (op_func),
    .shamt    (shamt),
    .a_val    (a_val),
    .b_val    (b_val),
    .imm      (imm),
    .result   (result),
    .ovf      (ovf)
  );

  function automatic string req_of(input logic [5:0] mj, input logic [5:0] fn);
    if (mj == 6'h00) begin
      case (fn)
        6'h20, 6'h22: return "R1/R4";
        6'h21, 6'h23: return "R2";
        6'h24, 6'h25, 6'h26: return "R5";
        6'h2A: return "R6";
        6'h2B: return "R7";
        6'h00, 6'h02, 6'h03: return "R8";
        6'h04, 6'h06, 6'h07: return "R9";
        default: return "R10";
      endcase
    end
    case (mj)
      6'h08: return "R1/R4";
      6'h09: return "R2";
      6'h0A: return "R6";
      6'h0B: return "R7";
      6'h0C, 6'h0D, 6'h0E: return "R5";
      6'h0F: return "R3";
      default: return "R10";
    endcase
  endfunction

  // behavioural reference: 64-bit integers, no structural copy
  task automatic model(input logic [5:0] mj, input logic [5:0] fn, input logic [4:0] sa,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                       output logic [31:0] r, output logic o);
    longint sa64, sb64, sx64, ex;
    longint unsigned ua, ub, ux;
    sa64 = longint'($signed(a));
    sb64 = longint'($signed(b));
    sx64 = longint'($signed(im));
    ua = longint'(a); ub = longint'(b); ux = longint'(sx64) & 64'hFFFF_FFFF;
    r = 32'h0; o = 1'b0;
    if (mj == 6'h00) begin
      case (fn)
        6'h20: begin ex = sa64 + sb64; r = ex[31:0]; o = (ex > 64'sd2147483647) || (ex < -64'sd2147483648); end
        6'h21: r = a + b;
        6'h22: begin ex = sa64 - sb64; r = ex[31:0]; o = (ex > 64'sd2147483647) || (ex < -64'sd2147483648); end
        6'h23: r = a - b;
        6'h24: r = a & b;
        6'h25: r = a | b;
        6'h26: r = a ^ b;
        6'h2A: r = {31'h0, sa64 < sb64};
        6'h2B: r = {31'h0, ua < ub};
        6'h00: r = a << sa;
        6'h02: r = a >> sa;
        6'h03: r = $unsigned($signed(a) >>> sa);
        6'h04: r = a << (b % 32);
        6'h06: r = a >> (b % 32);
        6'h07: r = $unsigned($signed(a) >>> (b % 32));
        default: r = 32'h0;
      endcase
    end else begin
      case (mj)
        6'h08: begin ex = sa64 + sx64; r = ex[31:0]; o = (ex > 64'sd2147483647) || (ex < -64'sd2147483648); end
        6'h09: r = a + 32'(sx64);
        6'h0A: r = {31'h0, sa64 < sx64};
        6'h0B: r = {31'h0, ua < ux};
        6'h0C: r = a & {16'h0, im};
        6'h0D: r = a | {16'h0, im};
        6'h0E: r = a ^ {16'h0, im};
        6'h0F: r = {im, 16'h0};
        default: r = 32'h0;
      endcase
    end
  endtask

  task automatic apply(input logic [5:0] mj, input logic [5:0] fn, input logic [4:0] sa,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                       input string why);
    logic [31:0] er;
    logic        eo;
    @(negedge clk);
    op_major = mj; op_func = fn; shamt = sa; a_val = a; b_val = b; imm = im;
    @(posedge clk);
    #1;
    model(mj, fn, sa, a, b, im, er, eo);
    n_vec++;
    if (result !== er || ovf !== eo) begin
      n_bad++;
      $display("FAIL %s %s: major=%h func=%h a=%h b=%h imm=%h sh=%0d result=%h ovf=%b expected result=%h ovf=%b",
               req_of(mj, fn), why, mj, fn, a, b, im, sa, result, ovf, er, eo);
    end
  endtask

  function automatic logic [31:0] pick_val(input int sel, input logic [31:0] rnd);
    case (sel)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      4: return 32'h0000_0001;
      5: return {27'h0, rnd[4:0]};
      default: return rnd;
    endcase
  endfunction

  localparam logic [11:0] OPS [0:25] = '{
    {6'h00,6'h20},{6'h00,6'h21},{6'h00,6'h22},{6'h00,6'h23},{6'h00,6'h24},
    {6'h00,6'h25},{6'h00,6'h26},{6'h00,6'h2A},{6'h00,6'h2B},{6'h00,6'h00},
    {6'h00,6'h02},{6'h00,6'h03},{6'h00,6'h04},{6'h00,6'h06},{6'h00,6'h07},
    {6'h08,6'h15},{6'h09,6'h2A},{6'h0A,6'h01},{6'h0B,6'h3F},{6'h0C,6'h20},
    {6'h0D,6'h00},{6'h0E,6'h11},{6'h0F,6'h22},{6'h00,6'h3E},{6'h3F,6'h20},
    {6'h12,6'h00}};

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: all-zero inputs give zero result, no overflow (R1)
    apply(6'h00, 6'h20, 5'd0, 32'h0, 32'h0, 16'h0, "R1 zero inputs");
    // R1/R4 overflow boundaries
    apply(6'h00, 6'h20, 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, "R4 add positive overflow");
    apply(6'h00, 6'h20, 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, "R4 add negative overflow");
    apply(6'h00, 6'h22, 5'd0, 32'h8000_0000, 32'h1, 16'h0, "R4 sub overflow");
    apply(6'h00, 6'h22, 5'd0, 32'h0, 32'h8000_0000, 16'h0, "R4 negate minimum");
    apply(6'h08, 6'h00, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, "R4 addi overflow");
    apply(6'h08, 6'h00, 5'd0, 32'h5, 32'hDEAD_BEEF, 16'hFFFF, "R1 addi sign extension");
    // R2 unsigned forms never flag
    apply(6'h00, 6'h21, 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, "R2 addu wrap");
    apply(6'h00, 6'h23, 5'd0, 32'h8000_0000, 32'h1, 16'h0, "R2 subu wrap");
    apply(6'h09, 6'h00, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, "R2 addiu wrap");
    // R3 / R11 constant build
    apply(6'h0F, 6'h00, 5'd0, 32'h1234_5678, 32'hFFFF_FFFF, 16'h4083, "R3 lui");
    apply(6'h0D, 6'h00, 5'd0, result, 32'hAAAA_AAAA, 16'hF3A4, "R11 ori after lui");
    if (result !== 32'h4083_F3A4) begin
      n_bad++;
      $display("FAIL R11 constant build: result=%h expected=%h", result, 32'h4083_F3A4);
    end
    n_vec++;
    // R5 zero extension, B ignored
    apply(6'h0C, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h1234_0000, 16'h8001, "R5 andi zero-extend");
    apply(6'h0E, 6'h00, 5'd0, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 16'hFFFF, "R5 xori");
    // R6 / R7 compares past the subtraction overflow
    apply(6'h00, 6'h2A, 5'd0, 32'h7FFF_FFF0, 32'h8000_0010, 16'h0, "R6 large pos vs large neg");
    apply(6'h00, 6'h2A, 5'd0, 32'h8000_0010, 32'h7FFF_FFF0, 16'h0, "R6 large neg vs large pos");
    apply(6'h0A, 6'h00, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, "R6 slti negative immediate");
    apply(6'h00, 6'h2B, 5'd0, 32'h7FFF_FFF0, 32'h8000_0010, 16'h0, "R7 sltu");
    apply(6'h0B, 6'h00, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, "R7 sltiu sign-extended imm");
    // R8 / R9 shifts
    apply(6'h00, 6'h03, 5'd31, 32'h8000_0000, 32'h0, 16'h0, "R8 sra by 31");
    apply(6'h00, 6'h00, 5'd0, 32'hA5A5_A5A5, 32'h0, 16'h0, "R8 sll by 0");
    apply(6'h00, 6'h07, 5'd0, 32'h8000_0000, 32'hFFFF_FFE5, 16'h0, "R9 srav uses low 5 bits");
    apply(6'h00, 6'h04, 5'd0, 32'h0000_0001, 32'h0000_0020, 16'h0, "R9 sllv count 32 wraps to 0");
    // R10 unknown codes
    apply(6'h00, 6'h3E, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, "R10 unknown function");
    apply(6'h3F, 6'h20, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, "R10 unknown major");
    // random sweep across all groups
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] op;
      op = OPS[$urandom_range(0, 25)];
      apply(op[11:6], op[5:0], 5'($urandom), pick_val($urandom_range(0, 9), $urandom),
            pick_val($urandom_range(0, 9), $urandom), 16'($urandom), "random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule